// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Transfer Engine

This block moves words between one peripheral port and main memory without the processor touching each word. Software first loads the memory pointer, the word counter and the peripheral address through a small register port, then writes the control register with the start bit set. From then on the engine waits for the peripheral to raise its request. It then asks the processor for the bus and waits for the grant. Once the bus is granted it acknowledges the peripheral and moves one word per clock, stepping the pointer and the counter after each word.

The counter is loaded with the two's complement of the length and counts upward. The job ends when the counter wraps to zero. At that point the engine clears its busy flag, sets done and, if enabled, raises a level interrupt that stays up until software reads the status register. Three release policies decide how long the bus is held. Single mode gives the bus back after every word. Block mode keeps it until the whole job is finished. Demand mode keeps it for as long as the peripheral keeps requesting.

Top module: `dma_engine`

## Requirements
- R1: After reset the engine is idle: hold, dack and irq are low, and every register reads zero.
- R2: Register select 1 writes and reads the memory pointer, select 2 the word counter (low CW bits) and select 3 the peripheral address. A read of select 0 returns status: bit0 busy, bit1 done, bits 3:2 mode, bit4 direction, bit5 interrupt enable. A write of select 0 loads the same mode, direction and enable fields and starts the job when bit0 is 1.
- R3: hold rises only after a request seen while busy. dack is high only while hold and bus_grant are both high, and every word moves in a dack cycle.
- R4: Each word moved increments the memory pointer by one and the word counter by one, wrapping at their widths, so that a job of N words ends with the pointer advanced by N.
- R5: Mode 0 (single) drops hold after every word for at least one cycle, so a job of N words takes N separate bus tenures.
- R6: Mode 1 (block) moves the whole job in one bus tenure while the grant stays high, whatever the request does after the first word.
- R7: Modes 2 and 3 (demand) move a word only in a cycle where the request is high, and give the bus back as soon as the request falls.
- R8: When the word moved has the counter at all ones, the counter wraps to zero, busy clears and done sets. A counter loaded with zero therefore moves 2^CW words. irq equals done AND interrupt enable.
- R9: Every register write, control included, is ignored while busy.
- R10: A status read (reg_rd with select 0) clears done, and with it irq.
- R11: Direction 0 reads the peripheral and writes memory (mem_wdata = dev_rdata). Direction 1 reads memory and writes the peripheral (dev_wdata = mem_rdata). dev_addr always shows the programmed peripheral address.
- R12: While not busy, a raised request never causes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Status read strobe (clears done on select 0) |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational on reg_sel) |
| dreq | input | 1 | Peripheral request |
| dack | output | 1 | Peripheral acknowledge |
| hold | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| irq | output | 1 | End-of-job interrupt, level |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| dev_addr | output | AW | Peripheral address |
| dev_rd | output | 1 | Peripheral read strobe |
| dev_wr | output | 1 | Peripheral write strobe |
| dev_wdata | output | DW | Peripheral write data |
| dev_rdata | input | DW | Peripheral read data, same cycle |

## Verification
The bench builds the engine with AW=8, DW=8 and CW=4. The 4-bit counter lets a full-range job of 16 words, loaded as a counter of zero, run to the wrap in a few dozen cycles. The 8-bit pointer lets such a job start at 248 and cross the top of memory. This small configuration makes it cheap to sweep every mode against both directions and several lengths, and to count bus tenures exactly for each mode: N for single, one for block, and ceil(N/3) for demand when the peripheral drops its request after every third word.

// File: rtl/dma_engine.sv
`timescale 1ns/1ps
module dma_engine #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          dreq,
  output logic          dack,
  output logic          hold,
  input  logic          bus_grant,
  output logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] dev_addr,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} st_t;

  st_t           st;
  logic          busy, done, ien, dir;
  logic [1:0]    mode;
  logic [AW-1:0] addr, dadr;
  logic [CW-1:0] cnt;
  logic [AW-1:0] stat;

  wire demand = mode[1];
  wire block  = !mode[1] && mode[0];
  wire last   = &cnt;
  wire wr_ok  = reg_wr && !busy;

  assign hold = (st != S_IDLE);
  assign dack = (st == S_XFER) && bus_grant;
  wire   xfer = dack && (!demand || dreq);

  assign irq       = done && ien;
  assign mem_addr  = addr;
  assign mem_wr    = xfer && !dir;
  assign mem_rd    = xfer && dir;
  assign mem_wdata = dev_rdata;
  assign dev_addr  = dadr;
  assign dev_rd    = xfer && !dir;
  assign dev_wr    = xfer && dir;
  assign dev_wdata = mem_rdata;

  always_comb begin
    stat = '0;
    stat[5:0] = {ien, dir, mode, done, busy};
    case (reg_sel)
      2'd0:    reg_rdata = stat;
      2'd1:    reg_rdata = addr;
      2'd2:    reg_rdata = AW'(cnt);
      default: reg_rdata = dadr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ien  <= 1'b0;
      dir  <= 1'b0;
      mode <= 2'd0;
      addr <= '0;
      cnt  <= '0;
      dadr <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_sel)
          2'd0: begin
            busy <= reg_wdata[0];
            mode <= reg_wdata[3:2];
            dir  <= reg_wdata[4];
            ien  <= reg_wdata[5];
          end
          2'd1:    addr <= reg_wdata;
          2'd2:    cnt  <= reg_wdata[CW-1:0];
          default: dadr <= reg_wdata;
        endcase
      end
      if (xfer) begin
        addr <= addr + 1'b1;
        cnt  <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      done <= 1'b0;
    else if (xfer && last)
      done <= 1'b1;
    else if (reg_rd && reg_sel == 2'd0)
      done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE: if (busy && dreq) st <= S_REQ;
        S_REQ:  if (bus_grant) st <= S_XFER;
        default: begin
          if (!bus_grant) st <= S_REQ;
          else if (xfer) begin
            if (last || !(block || demand)) st <= S_IDLE;
          end else st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_engine_chk.sv
`timescale 1ns/1ps
module dma_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          dack,
  input logic          bus_grant,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          busy,
  input logic          done,
  input logic          xfer,
  input logic [1:0]    mode,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] addr
);
  // R3
  dack_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (hold && bus_grant));

  // R4
  step_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cnt == CW'($past(cnt) + 1'b1)) && (addr == AW'($past(addr) + 1'b1)));

  // R5
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode == 2'd0) |=> !hold);

  // R8
  done_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer && (&cnt)));

  // R12
  idle_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !hold);

  // R11
  one_mem_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .dack(dack), .bus_grant(bus_grant),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done), .xfer(xfer),
  .mode(mode), .cnt(cnt), .addr(addr)
);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;
  localparam int AW = 8, DW = 8, CW = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_wdata = 0, reg_rdata;
  logic dreq = 0, dack, hold, bus_grant = 0, irq;
  logic [AW-1:0] mem_addr, dev_addr;
  logic mem_rd, mem_wr, dev_rd, dev_wr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;

  int total = 0, bad = 0;
  int plen = 0, dbase = 0, blim = 255;
  bit active = 0;
  int dseq = 0, xfers = 0, rises = 0, burst = 0, dack_bad = 0;
  bit hold_q = 0;
  logic [7:0] mem [256];
  logic [7:0] dev_log [256];

  always #2 clk = ~clk;

  dma_engine #(.AW(AW), .DW(DW), .CW(CW)) i_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .hold(hold), .bus_grant(bus_grant), .irq(irq), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );

  function automatic int dpat(int i, int n); return (i*37 + n*5 + 1) & 255; endfunction
  function automatic int mpat(int a, int n); return ((a*11 + 3) ^ n) & 255; endfunction

  assign dev_rdata = 8'(dpat(dseq - dbase, plen));
  assign mem_rdata = 8'(mpat(int'(mem_addr), plen));

  always @(posedge clk) bus_grant <= hold && rst_n;

  always @(negedge clk) begin
    dreq = active && (burst < blim);
    #1;
    if (dack && !bus_grant) dack_bad++;
    if (hold && !hold_q) rises++;
    hold_q = hold;
    if (dev_rd || dev_wr) begin
      xfers++;
      if (dev_wr) dev_log[dseq & 255] = dev_wdata;
      if (mem_wr) mem[mem_addr] = mem_wdata;
      dseq++;
    end
    if (!hold) burst = 0;
    else if (dev_rd || dev_wr) burst++;
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input int d);
    @(negedge clk);
    reg_sel = s; reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rreg(input logic [1:0] s, output int v);
    @(negedge clk);
    reg_sel = s;
    #1 v = int'(reg_rdata);
  endtask

  task automatic run(int mode, int dir, int start, int len, int lim);
    int v, n, x0, r0, b0, ien, exp_r, errs;
    ien = len % 2;
    plen = len; blim = lim; dbase = dseq;
    wreg(1, start);
    wreg(2, (16 - len) % 16);
    wreg(3, 8'hA0 + mode);
    rreg(1, v); chk("R2 pointer readback", v, start);
    rreg(2, v); chk("R2 counter readback", v, (16 - len) % 16);
    rreg(3, v); chk("R2 peripheral address readback", v, 8'hA0 + mode);
    x0 = xfers; r0 = rises; b0 = dack_bad;
    wreg(0, 1 | (mode << 2) | (dir << 4) | (ien << 5));
    wreg(1, 8'h55);
    wreg(3, 8'h11);
    wreg(0, 8'h09 ^ (mode << 2));
    rreg(0, v);
    chk("R9 control write while busy ignored", v & 8'h3d, 1 | (mode << 2) | (dir << 4) | (ien << 5));
    chk("R12 no hold before request", rises - r0, 0);
    active = 1;
    n = 0;
    do begin
      @(negedge clk); #1;
      v = int'(reg_rdata);
      n++;
    end while ((v & 1) && n < 3000);
    chk("R8 busy clears at terminal count", v & 1, 0);
    chk("R8 done set", (v >> 1) & 1, 1);
    chk("R8 irq follows enable", int'(irq), ien);
    chk("R4 words moved", xfers - x0, len);
    exp_r = (mode == 0) ? len : (mode == 1) ? 1 : (len + lim - 1) / lim;
    if (mode == 0) chk("R5 single tenures", rises - r0, exp_r);
    else if (mode == 1) chk("R6 block tenures", rises - r0, exp_r);
    else chk("R7 demand tenures", rises - r0, exp_r);
    chk("R3 dack only with grant", dack_bad - b0, 0);
    rreg(1, v); chk("R4 pointer advanced", v, (start + len) & 255);
    rreg(2, v); chk("R8 counter wrapped", v, 0);
    chk("R11 peripheral address held", int'(dev_addr), 8'hA0 + mode);
    errs = 0;
    for (int i = 0; i < len; i++) begin
      if (dir == 0) begin
        if (int'(mem[(start + i) & 255]) != dpat(i, len)) errs++;
      end else begin
        if (int'(dev_log[(dbase + i) & 255]) != mpat((start + i) & 255, len)) errs++;
      end
    end
    chk("R11 data path", errs, 0);
    r0 = rises;
    repeat (6) @(negedge clk);
    chk("R12 request ignored when idle", rises - r0, 0);
    active = 0;
    @(negedge clk);
    reg_sel = 0; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0; #1;
    chk("R10 status read clears done", (int'(reg_rdata) >> 1) & 1, 0);
    chk("R10 irq cleared", int'(irq), 0);
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 hold after reset", int'(hold), 0);
    chk("R1 dack after reset", int'(dack), 0);
    chk("R1 irq after reset", int'(irq), 0);
    rreg(0, v); chk("R1 status after reset", v, 0);
    rreg(1, v); chk("R1 pointer after reset", v, 0);
    rreg(2, v); chk("R1 counter after reset", v, 0);
    for (int m = 0; m < 3; m++)
      for (int d = 0; d < 2; d++)
        foreach (lens[k])
          run(m == 2 ? 2 + d : m, d,
              lens[k] == 16 ? 248 : (lens[k]*13 + m*50 + d*7) & 255,
              lens[k], m == 2 ? 3 : 255);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int lens [5] = '{1, 2, 3, 7, 16};

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule